// File: doc/BRIEF.md
# Shared-Region Bus Requester Controller

This controller sits beside a secondary processor that owns most of its memory map outright but must borrow one region, the shared region, from a primary bus master. Local accesses aimed anywhere else are launched at once. An access aimed at the shared region instead raises a bus request toward the primary master and stalls the local requester with a wait signal. The access is launched only once the grant has been sampled high on enough consecutive edges while the request is up. When the access completes, the request is dropped. If the shared region holds synchronous DRAM, the drop is postponed by an auto-precharge interval first.

The primary master may take its grant back at any time. An access already launched runs to its end, but no further shared-region access is launched until the grant qualifies again. The controller also drives an enable for an external address/control buffer and a delayed copy of its request, which is routed to the master's request input so that turning the buffer off cannot overlap the start of a master-side cycle. Refresh requests aimed at the shared region are dropped. The sharing mode and the memory kind are captured only during power-on reset and survive a soft reset.

The state machine has five states: IDLE (no request), REQ (request up, waiting for a qualified grant), LAUNCH (one cycle, the access is started), BUSY (the access is in flight) and PRECH (auto-precharge hold before release). Its transitions are: IDLE to REQ on a pending shared access. REQ to LAUNCH once the grant is qualified and still high. LAUNCH to BUSY unconditionally. BUSY to LAUNCH on completion, when another shared access is pending and the grant is still qualified. BUSY to REQ on completion, when another access is pending but the grant has lapsed. BUSY to PRECH on completion, with nothing pending, in synchronous-DRAM mode. BUSY to IDLE in the same case otherwise. PRECH to IDLE when the hold count runs out. Either reset returns the machine to IDLE.

Top module: `srb_requester`

## Requirements
- R1: When the sharing mode is off, or the access region differs from SHARED_REGION, `acc_start` equals `acc_req` in the same cycle, `acc_wait` stays 0 and `bus_req` stays 0.
- R2: A shared-region access (region equal to SHARED_REGION, sharing mode on, `acc_refresh` 0) presented in IDLE raises `bus_req` on the next clock edge, and `acc_wait` is 1 for every cycle the access is pending and not yet started.
- R3: A shared access starts (`acc_start` high for exactly one cycle) on the edge after `bus_gnt` has been sampled high on QUAL_CYC (default 2) consecutive edges while `bus_req` was high, provided `bus_gnt` is still high at that edge; never earlier.
- R4: In the non-DRAM mode, with no further shared access pending, `bus_req` falls on the edge that samples `shr_done` high.
- R5: If `bus_gnt` drops while an access is in flight and another shared access is pending at completion, `bus_req` stays high and the next access waits until the grant qualifies again as in R3.
- R6: `buf_en` rises on the first edge that samples `bus_gnt` high while `bus_req` is high, stays high while `bus_req` is high even if the grant drops, and falls on the same edge as `bus_req`.
- R7: `req_dly` is `bus_req` delayed by REQ_DLY (default 2) clock edges.
- R8: In synchronous-DRAM mode, `bus_req` stays high for PRECH_CYC (default 3) cycles after the edge that samples `shr_done`, then falls.
- R9: A request with `acc_refresh` 1 aimed at the shared region in sharing mode is ignored: no `acc_start`, no `acc_wait`, no `bus_req`. A refresh aimed at another region starts at once, as in R1.
- R10: `cfg_share_en` and `cfg_sdram` are captured on every edge while `por_n` is 0 and held afterwards. A soft reset (`soft_rst_n` 0) returns the controller to IDLE, with `bus_req`, `buf_en` and `req_dly` at 0, but keeps the captured configuration.
- R11: If another shared access is pending when `shr_done` arrives and the grant is still qualified, that access starts on the next edge without `bus_req` dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| por_n | input | 1 | Power-on reset, active low, synchronous; captures the configuration |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous; configuration kept |
| cfg_share_en | input | 1 | Sharing mode enable, captured during power-on reset |
| cfg_sdram | input | 1 | Shared region is synchronous DRAM, captured during power-on reset |
| acc_req | input | 1 | Local access request, held until `acc_start` |
| acc_region | input | REGION_W | Region index of the requested access |
| acc_refresh | input | 1 | The request is a refresh |
| shr_done | input | 1 | One-cycle pulse: the launched shared access has completed |
| bus_gnt | input | 1 | Grant from the primary master |
| acc_start | output | 1 | Launch the requested access this cycle |
| acc_wait | output | 1 | Stall: a shared access is pending and not started |
| bus_req | output | 1 | Bus request toward the primary master |
| buf_en | output | 1 | Enable for the external address/control buffer |
| req_dly | output | 1 | Delayed copy of `bus_req` for the master's request input |

## Verification
The bench builds the block with its defaults: a 3-bit region index with region 2 shared, a two-edge grant qualification, a three-cycle precharge hold and a two-edge request delay. With windows this short, each expected edge of the qualification count, of the precharge hold and of the delayed request copy falls a handful of cycles after its cause. Every such edge is checked at an exact cycle, together with grant withdrawal followed by requalification, back-to-back launches and the three configuration cases reached through repeated power-on resets.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_LAUNCH,
        ST_BUSY,
        ST_PRECH
    } srb_state_e;

    typedef struct packed {
        logic share_en;
        logic sdram;
    } srb_cfg_t;

endpackage

// File: rtl/srb_cfg_hold.sv
module srb_cfg_hold
    import srb_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  srb_cfg_t cfg_in,
    output srb_cfg_t cfg_q
);

    // Configuration follows the pins only while power-on reset is held.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/srb_gnt_qual.sv
module srb_gnt_qual #(
    parameter int QUAL_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic gnt,
    output logic qualified
);

    localparam int CNT_W = $clog2(QUAL_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_CYC);

    logic [CNT_W-1:0] seen_cnt;

    // Consecutive edges with the grant high while requesting, saturating.
    always_ff @(posedge clk) begin
        if (rst || !(req && gnt)) begin
            seen_cnt <= '0;
        end else if (seen_cnt != CNT_TOP) begin
            seen_cnt <= seen_cnt + 1'b1;
        end
    end

    assign qualified = (seen_cnt == CNT_TOP);

endmodule

// File: rtl/srb_delay_line.sv
module srb_delay_line #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_shift
            logic [DEPTH-1:0] taps;
            always_ff @(posedge clk) begin
                if (rst) begin
                    taps <= '0;
                end else if (DEPTH == 1) begin
                    taps <= d;
                end else begin
                    taps <= {taps[DEPTH-2:0], d};
                end
            end
            assign q = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/srb_requester.sv
module srb_requester
    import srb_pkg::*;
#(
    parameter int REGION_W      = 3,
    parameter int SHARED_REGION = 2,
    parameter int QUAL_CYC      = 2,
    parameter int PRECH_CYC     = 3,
    parameter int REQ_DLY       = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                soft_rst_n,
    input  logic                cfg_share_en,
    input  logic                cfg_sdram,
    input  logic                acc_req,
    input  logic [REGION_W-1:0] acc_region,
    input  logic                acc_refresh,
    input  logic                shr_done,
    input  logic                bus_gnt,
    output logic                acc_start,
    output logic                acc_wait,
    output logic                bus_req,
    output logic                buf_en,
    output logic                req_dly
);

    localparam logic [REGION_W-1:0] SHR_ID = REGION_W'(SHARED_REGION);
    localparam int PC_W = $clog2(PRECH_CYC + 2);
    localparam logic [PC_W-1:0] PC_LOAD = (PRECH_CYC > 0) ? PC_W'(PRECH_CYC - 1) : '0;
    localparam bit USE_PRECH = (PRECH_CYC > 0);

    srb_state_e state, state_nx;
    srb_cfg_t   cfg_q;
    logic       rst;
    logic       is_shared;
    logic       shr_pend;
    logic       bypass_go;
    logic       gnt_ok;
    logic       shr_start;
    logic       sdram_mode;
    logic [PC_W-1:0] prech_cnt;

    assign rst = !por_n || !soft_rst_n;

    srb_cfg_hold u_cfg (
        .clk    (clk),
        .por_n  (por_n),
        .cfg_in ('{share_en: cfg_share_en, sdram: cfg_sdram}),
        .cfg_q  (cfg_q)
    );

    srb_gnt_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .req       (bus_req),
        .gnt       (bus_gnt),
        .qualified (gnt_ok)
    );

    srb_delay_line #(.DEPTH(REQ_DLY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (bus_req),
        .q   (req_dly)
    );

    // Request classification.
    assign sdram_mode = cfg_q.sdram;
    assign is_shared  = cfg_q.share_en && (acc_region == SHR_ID);
    assign shr_pend   = acc_req && is_shared && !acc_refresh;
    assign bypass_go  = acc_req && !is_shared;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (shr_pend) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (gnt_ok && bus_gnt) state_nx = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_nx = ST_BUSY;
            end
            ST_BUSY: begin
                if (shr_done) begin
                    if (shr_pend && gnt_ok && bus_gnt) begin
                        state_nx = ST_LAUNCH;
                    end else if (shr_pend) begin
                        state_nx = ST_REQ;
                    end else if (sdram_mode && USE_PRECH) begin
                        state_nx = ST_PRECH;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_PRECH: begin
                if (prech_cnt == '0) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register, precharge counter and buffer enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            prech_cnt <= '0;
            buf_en    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_PRECH && state != ST_PRECH) begin
                prech_cnt <= PC_LOAD;
            end else if (state == ST_PRECH && prech_cnt != '0) begin
                prech_cnt <= prech_cnt - 1'b1;
            end
            if (state_nx == ST_IDLE) begin
                buf_en <= 1'b0;
            end else if (bus_req && bus_gnt) begin
                buf_en <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        bus_req   = (state != ST_IDLE);
        shr_start = (state == ST_LAUNCH);
        acc_start = shr_start || bypass_go;
        acc_wait  = shr_pend && !shr_start;
    end

endmodule

// File: rtl/srb_requester_chk.sv
module srb_requester_chk #(
    parameter int PRECH_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic acc_req,
    input logic acc_refresh,
    input logic is_shared,
    input logic shr_done,
    input logic bus_gnt,
    input logic shr_start,
    input logic sdram_mode,
    input logic acc_start,
    input logic acc_wait,
    input logic bus_req,
    input logic buf_en
);

    // Cycles since the last completion seen while requesting, saturating.
    logic [31:0] since_done;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_done <= '0;
        end else if (shr_done && bus_req) begin
            since_done <= '0;
        end else if (since_done <= 32'(PRECH_CYC)) begin
            since_done <= since_done + 32'd1;
        end
    end

    // R1: a bypassed access never raises the bus request
    p_bypass_no_req_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !is_shared && !bus_req) |=> !bus_req);

    // R2: a shared launch only happens with the request up
    p_launch_with_req_r2: assert property (@(posedge clk) disable iff (rst)
        shr_start |-> bus_req && $past(bus_req));

    // R3: launch needs the grant on the two preceding edges
    p_launch_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
        shr_start |-> $past(bus_gnt) && $past(bus_gnt, 2));

    // R3: the launch pulse lasts one cycle
    p_launch_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        shr_start |=> !shr_start);

    // R6: buffer enable only within the request window
    p_buf_in_req_r6: assert property (@(posedge clk) disable iff (rst)
        buf_en |-> bus_req);

    // R6: buffer turns on only after a grant was seen
    p_buf_rise_gnt_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_en) |-> $past(bus_gnt));

    // R8: release in DRAM mode waits out the precharge interval
    p_prech_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_req) && sdram_mode) |-> (since_done >= 32'(PRECH_CYC)));

    // R9: refresh requests are never stalled
    p_refresh_no_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_refresh) |-> !acc_wait);

    // R2: stall and launch are exclusive
    p_wait_excl_start_r2: assert property (@(posedge clk) disable iff (rst)
        acc_wait |-> !acc_start);

endmodule

bind srb_requester srb_requester_chk #(.PRECH_CYC(PRECH_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_req     (acc_req),
    .acc_refresh (acc_refresh),
    .is_shared   (is_shared),
    .shr_done    (shr_done),
    .bus_gnt     (bus_gnt),
    .shr_start   (shr_start),
    .sdram_mode  (sdram_mode),
    .acc_start   (acc_start),
    .acc_wait    (acc_wait),
    .bus_req     (bus_req),
    .buf_en      (buf_en)
);

// File: tb/tb_srb_requester.sv
module tb_srb_requester;

    localparam int CLK_PERIOD = 10;
    localparam int REGION_W   = 3;
    localparam logic [REGION_W-1:0] SHR = 3'd2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic soft_rst_n = 1'b1;
    logic cfg_share_en = 1'b1;
    logic cfg_sdram = 1'b0;
    logic acc_req = 1'b0;
    logic [REGION_W-1:0] acc_region = '0;
    logic acc_refresh = 1'b0;
    logic shr_done = 1'b0;
    logic bus_gnt = 1'b0;
    logic acc_start, acc_wait, bus_req, buf_en, req_dly;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    srb_requester dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .cfg_share_en(cfg_share_en), .cfg_sdram(cfg_sdram),
        .acc_req(acc_req), .acc_region(acc_region), .acc_refresh(acc_refresh),
        .shr_done(shr_done), .bus_gnt(bus_gnt),
        .acc_start(acc_start), .acc_wait(acc_wait), .bus_req(bus_req),
        .buf_en(buf_en), .req_dly(req_dly)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic expect_start(int at);
        exp_q.push_back(at);
    endtask

    task automatic power_on(logic share, logic sdram);
        cfg_share_en = share;
        cfg_sdram    = sdram;
        por_n        = 1'b0;
        repeat (3) step();
        por_n        = 1'b1;
        step();
    endtask

    // Monitor: every launch is popped against the expected cycle.
    always @(negedge clk) begin
        if (por_n && soft_rst_n && acc_start === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R3 unexpected acc_start at cycle %0d: got 1 expected 0", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL R3 acc_start cycle: got %0d expected %0d", cyc, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        power_on(1'b1, 1'b0);
        check("R10 reset bus_req", bus_req, 0);
        check("R10 reset buf_en", buf_en, 0);
        check("R10 reset req_dly", req_dly, 0);
        check("R10 reset acc_start", acc_start, 0);

        // R1: bypass region
        acc_region = 3'd0; acc_req = 1'b1;
        expect_start(cyc);
        #1;
        check("R1 bypass start", acc_start, 1);
        check("R1 bypass wait", acc_wait, 0);
        step();
        acc_req = 1'b0;
        check("R1 bypass no bus_req", bus_req, 0);
        step();

        // R2 R3 R4 R6 R7: single shared access, grant arrives late
        acc_region = SHR; acc_req = 1'b1; bus_gnt = 1'b0; n = cyc;
        #1;
        check("R2 wait while pending", acc_wait, 1);
        step();
        check("R2 bus_req raised", bus_req, 1);
        check("R6 buf_en before grant", buf_en, 0);
        bus_gnt = 1'b1;
        expect_start(n + 4);
        step();
        check("R6 buf_en after grant", buf_en, 1);
        check("R7 req_dly still low", req_dly, 0);
        step();
        check("R3 no early start", acc_start, 0);
        check("R2 still waiting", acc_wait, 1);
        check("R7 req_dly high", req_dly, 1);
        step();
        check("R3 start", acc_start, 1);
        acc_req = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R4 bus_req dropped", bus_req, 0);
        check("R6 buf_en dropped", buf_en, 0);
        step();
        check("R7 req_dly still high", req_dly, 1);
        step();
        check("R7 req_dly dropped", req_dly, 0);
        bus_gnt = 1'b0;
        repeat (2) step();

        // R5: grant withdrawn during the access, second access pending
        acc_region = SHR; acc_req = 1'b1; bus_gnt = 1'b1; n = cyc;
        expect_start(n + 4);
        repeat (4) step();
        bus_gnt = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R5 bus_req held", bus_req, 1);
        check("R6 buf_en held after withdrawal", buf_en, 1);
        check("R5 pending stalled", acc_wait, 1);
        step();
        bus_gnt = 1'b1;
        expect_start(n + 10);
        step();
        step();
        check("R5 no start before requalify", acc_start, 0);
        step();
        check("R5 start after requalify", acc_start, 1);
        acc_req = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R4 release after requalified access", bus_req, 0);
        bus_gnt = 1'b0;
        repeat (3) step();

        // R11: back-to-back shared accesses
        acc_region = SHR; acc_req = 1'b1; bus_gnt = 1'b1; n = cyc;
        expect_start(n + 4);
        expect_start(n + 6);
        repeat (5) step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R11 bus_req kept", bus_req, 1);
        check("R11 second start", acc_start, 1);
        acc_req = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R11 release", bus_req, 0);
        bus_gnt = 1'b0;
        repeat (3) step();

        // R9: refresh to the shared region ignored, elsewhere passed
        acc_region = SHR; acc_refresh = 1'b1; acc_req = 1'b1;
        #1;
        check("R9 refresh no start", acc_start, 0);
        check("R9 refresh no wait", acc_wait, 0);
        step();
        check("R9 refresh no bus_req", bus_req, 0);
        acc_region = 3'd5;
        expect_start(cyc);
        #1;
        check("R9 refresh other region starts", acc_start, 1);
        step();
        acc_req = 1'b0; acc_refresh = 1'b0;
        step();

        // R10: soft reset clears the handshake, keeps configuration
        cfg_share_en = 1'b0; cfg_sdram = 1'b1;
        acc_region = SHR; acc_req = 1'b1;
        step();
        step();
        check("R2 bus_req before soft reset", bus_req, 1);
        acc_req = 1'b0; soft_rst_n = 1'b0;
        repeat (2) step();
        soft_rst_n = 1'b1;
        check("R10 soft reset bus_req", bus_req, 0);
        check("R10 soft reset buf_en", buf_en, 0);
        step();
        check("R10 soft reset req_dly", req_dly, 0);
        acc_region = SHR; acc_req = 1'b1; n = cyc;
        step();
        check("R10 sharing mode retained", bus_req, 1);
        bus_gnt = 1'b1;
        expect_start(n + 4);
        repeat (3) step();
        acc_req = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R10 non-DRAM mode retained", bus_req, 0);
        bus_gnt = 1'b0;
        step();

        // R1 R10: new power-on with sharing off
        power_on(1'b0, 1'b0);
        acc_region = SHR; acc_req = 1'b1;
        expect_start(cyc);
        #1;
        check("R1 sharing off starts at once", acc_start, 1);
        step();
        acc_req = 1'b0;
        check("R1 sharing off no bus_req", bus_req, 0);
        step();

        // R8: synchronous DRAM precharge hold
        power_on(1'b1, 1'b1);
        acc_region = SHR; acc_req = 1'b1; bus_gnt = 1'b1; n = cyc;
        expect_start(n + 4);
        repeat (4) step();
        acc_req = 1'b0;
        step();
        shr_done = 1'b1;
        step();
        shr_done = 1'b0;
        check("R8 held after done", bus_req, 1);
        step();
        step();
        check("R8 held last precharge cycle", bus_req, 1);
        step();
        check("R8 released after precharge", bus_req, 0);
        bus_gnt = 1'b0;
        repeat (3) step();

        check("R3 all expected starts seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule